// File: doc/BRIEF.md
# Cursor Generator Host Register Port

This block gives a host processor indirect access to the control state of a hardware video cursor. A 16-bit bus reaches four word-aligned ports. Two of them load a shared 16-bit internal address one byte at a time. The other two move data at that address:

- a byte port reaches the control registers, which are the command byte, the cursor position, and the crosshair window origin and size;
- a word port reaches a 512-word cursor image RAM.

Every access on either data port advances the shared address by one. A host can therefore stream a whole register group, or the whole cursor image, after a single address load.

The pixel overlay logic is not part of this block. It takes the decoded register values straight from the output pins. It reads the cursor image through its own dedicated RAM read port, so it never competes with host traffic. Byte writes come with the same byte on both halves of the bus. Byte reads come back in the low half, with zero in the high half.

Top module: `cursor_host_port`

## Requirements
- R1: After reset every register output, the read data bus, the read-valid flag and the internal address are zero.
- R2: Port select code 0 writes the low byte and code 1 writes the high byte of the internal address, each from data bits 7:0. Reading either port returns that byte zero-extended and leaves the address unchanged.
- R3: Each access on port code 2 (register byte) touches the register at the current address and then adds one to the address. Register addresses are: 0x00 command, 0x01/0x02 cursor X low/high, 0x03/0x04 cursor Y low/high, then 0x05..0x0C as low/high pairs of window X, window Y, window width and window height.
- R4: A register read returns the byte in bits 7:0 with bits 15:8 at zero. The data bits 7:0 of a write are stored.
- R5: Cursor X and Y are 12-bit values. Their high-byte registers keep only data bits 3:0 and read back with bits 7:4 at zero. The window values are full 16-bit values.
- R6: A register write at an address above 0x0C changes no register output, and a register read there returns zero. The address still advances.
- R7: Each access on port code 3 (cursor map) writes or reads one 16-bit word at the current address, then adds one to the address. Addresses above 0x1FF write nothing and read zero.
- R8: The address wraps from 0xFFFF to 0x0000.
- R9: Read data and its valid flag appear in the cycle after the read request. The address advance caused by that read takes effect at the same edge.
- R10: The overlay RAM read port returns the word at its address one cycle later. When a host map write hits the same word in the same cycle, the overlay read returns the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_port | input | 2 | 0 addr low, 1 addr high, 2 register byte, 3 cursor map word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| cmd_o | output | 8 | Command register |
| cur_x_o | output | 12 | Cursor X position |
| cur_y_o | output | 12 | Cursor Y position |
| win_x_o | output | 16 | Window X origin |
| win_y_o | output | 16 | Window Y origin |
| win_w_o | output | 16 | Window width |
| win_h_o | output | 16 | Window height |
| ovl_addr | input | 9 | Overlay RAM read address |
| ovl_rdata | output | 16 | Overlay RAM read data |

## Verification
The host write to the cursor map and the overlay read of that same word can occur in the same cycle. The bench parks the overlay address on one word and writes that word from the host. One cycle later it expects the old contents, and one cycle after that the new contents. A second overlap is a read on a data port together with the address advance at the same edge. The scoreboard judges this by streaming back-to-back reads: each returned word must match the word for its own address, not the next one.

// File: rtl/cursor_host_port.sv
`timescale 1ns/1ps
module cursor_host_port #(
  parameter int MAP_DEPTH = 512,
  localparam int MAP_AW = $clog2(MAP_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_port,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic [7:0]        cmd_o,
  output logic [11:0]       cur_x_o,
  output logic [11:0]       cur_y_o,
  output logic [15:0]       win_x_o,
  output logic [15:0]       win_y_o,
  output logic [15:0]       win_w_o,
  output logic [15:0]       win_h_o,
  input  logic [MAP_AW-1:0] ovl_addr,
  output logic [15:0]       ovl_rdata
);
  localparam logic [1:0] P_ALO = 2'd0, P_AHI = 2'd1, P_REG = 2'd2, P_MAP = 2'd3;

  logic [15:0] ptr;
  logic [15:0] mem [MAP_DEPTH];
  logic [7:0]  reg_rd;

  wire wr      = bus_sel & bus_we;
  wire rd      = bus_sel & ~bus_we;
  wire step    = bus_sel & (bus_port == P_REG || bus_port == P_MAP);
  wire map_hit = int'(ptr) < MAP_DEPTH;
  wire [MAP_AW-1:0] map_idx = ptr[MAP_AW-1:0];
  wire [7:0] wb = bus_wdata[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n)                        ptr <= '0;
    else if (wr && bus_port == P_ALO)  ptr[7:0] <= wb;
    else if (wr && bus_port == P_AHI)  ptr[15:8] <= wb;
    else if (step)                     ptr <= ptr + 16'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_o <= '0; cur_x_o <= '0; cur_y_o <= '0;
      win_x_o <= '0; win_y_o <= '0; win_w_o <= '0; win_h_o <= '0;
    end else if (wr && bus_port == P_REG) begin
      case (ptr)
        16'h0000: cmd_o          <= wb;
        16'h0001: cur_x_o[7:0]   <= wb;
        16'h0002: cur_x_o[11:8]  <= wb[3:0];
        16'h0003: cur_y_o[7:0]   <= wb;
        16'h0004: cur_y_o[11:8]  <= wb[3:0];
        16'h0005: win_x_o[7:0]   <= wb;
        16'h0006: win_x_o[15:8]  <= wb;
        16'h0007: win_y_o[7:0]   <= wb;
        16'h0008: win_y_o[15:8]  <= wb;
        16'h0009: win_w_o[7:0]   <= wb;
        16'h000A: win_w_o[15:8]  <= wb;
        16'h000B: win_h_o[7:0]   <= wb;
        16'h000C: win_h_o[15:8]  <= wb;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ptr)
      16'h0000: reg_rd = cmd_o;
      16'h0001: reg_rd = cur_x_o[7:0];
      16'h0002: reg_rd = {4'h0, cur_x_o[11:8]};
      16'h0003: reg_rd = cur_y_o[7:0];
      16'h0004: reg_rd = {4'h0, cur_y_o[11:8]};
      16'h0005: reg_rd = win_x_o[7:0];
      16'h0006: reg_rd = win_x_o[15:8];
      16'h0007: reg_rd = win_y_o[7:0];
      16'h0008: reg_rd = win_y_o[15:8];
      16'h0009: reg_rd = win_w_o[7:0];
      16'h000A: reg_rd = win_w_o[15:8];
      16'h000B: reg_rd = win_h_o[7:0];
      16'h000C: reg_rd = win_h_o[15:8];
      default:  reg_rd = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr && bus_port == P_MAP && map_hit) mem[map_idx] <= bus_wdata;
    ovl_rdata <= mem[ovl_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) begin
        case (bus_port)
          P_ALO:   bus_rdata <= {8'h00, ptr[7:0]};
          P_AHI:   bus_rdata <= {8'h00, ptr[15:8]};
          P_REG:   bus_rdata <= {8'h00, reg_rd};
          default: bus_rdata <= map_hit ? mem[map_idx] : 16'h0000;
        endcase
      end
    end
  end
endmodule

module cursor_host_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [1:0]  bus_port,
  input logic [15:0] bus_wdata,
  input logic        bus_rvalid,
  input logic [15:0] ptr,
  input logic [7:0]  cmd_o,
  input logic [11:0] cur_x_o,
  input logic [11:0] cur_y_o,
  input logic [15:0] win_x_o,
  input logic [15:0] win_y_o,
  input logic [15:0] win_w_o,
  input logic [15:0] win_h_o
);
  a_r2_addr_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_port == 2'd0) |=>
      (ptr[7:0] == $past(bus_wdata[7:0]) && ptr[15:8] == $past(ptr[15:8])));

  a_r2_addr_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_port == 2'd1) |=>
      (ptr[15:8] == $past(bus_wdata[7:0]) && ptr[7:0] == $past(ptr[7:0])));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_port[1]) |=> ptr == $past(ptr) + 16'd1);

  a_r6_ignore_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_port == 2'd2 && ptr > 16'h000C) |=>
      ($stable(cmd_o) && $stable(cur_x_o) && $stable(cur_y_o) && $stable(win_x_o)
       && $stable(win_y_o) && $stable(win_w_o) && $stable(win_h_o)));

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |=> bus_rvalid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> !bus_rvalid);
endmodule

bind cursor_host_port cursor_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .ptr(ptr), .cmd_o(cmd_o), .cur_x_o(cur_x_o), .cur_y_o(cur_y_o),
  .win_x_o(win_x_o), .win_y_o(win_y_o), .win_w_o(win_w_o), .win_h_o(win_h_o)
);

// File: tb/sim_cursor_host_port.sv
`timescale 1ns/1ps
module sim_cursor_host_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_port = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic bus_rvalid;
  logic [7:0] cmd_o;
  logic [11:0] cur_x_o, cur_y_o;
  logic [15:0] win_x_o, win_y_o, win_w_o, win_h_o;
  logic [8:0] ovl_addr = 9'h0;
  logic [15:0] ovl_rdata;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  cursor_host_port u0 (.*);

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(input logic [1:0] p, input logic w, input logic [15:0] d);
    bus_sel = 1'b1; bus_we = w; bus_port = p; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wbyte(input logic [1:0] p, input logic [7:0] b);
    op(p, 1'b1, {b, b});
  endtask

  task automatic rd(input logic [1:0] p, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    op(p, 1'b0, 16'h0);
  endtask

  task automatic sel_addr(input logic [15:0] a);
    wbyte(2'd0, a[7:0]); wbyte(2'd1, a[15:8]);
  endtask

  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) chk(bus_rvalid, 1'b0, "R9 unexpected read data");
      else chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({8'h0, cmd_o}, 16'h0, "R1 cmd");
    chk({4'h0, cur_x_o}, 16'h0, "R1 cur_x");
    chk(win_h_o, 16'h0, "R1 win_h");
    chk(bus_rdata, 16'h0, "R1 rdata");
    chk({15'h0, bus_rvalid}, 16'h0, "R1 rvalid");
    rd(2'd0, 16'h0000, "R1 addr lo");
    rd(2'd1, 16'h0000, "R1 addr hi");
    // R2 address load and readback
    sel_addr(16'h1234);
    rd(2'd0, 16'h0034, "R2 addr lo");
    rd(2'd1, 16'h0012, "R2 addr hi");
    rd(2'd0, 16'h0034, "R2 addr unchanged");
    // R3 R4 R5 streaming register writes
    sel_addr(16'h0000);
    wbyte(2'd2, 8'h61);
    wbyte(2'd2, 8'h78); wbyte(2'd2, 8'hA5);
    wbyte(2'd2, 8'h9C); wbyte(2'd2, 8'hFE);
    wbyte(2'd2, 8'h11); wbyte(2'd2, 8'h22);
    wbyte(2'd2, 8'h33); wbyte(2'd2, 8'h44);
    wbyte(2'd2, 8'h55); wbyte(2'd2, 8'h66);
    wbyte(2'd2, 8'h77); wbyte(2'd2, 8'h88);
    chk({8'h0, cmd_o}, 16'h0061, "R3 cmd");
    chk({4'h0, cur_x_o}, 16'h0578, "R5 cur_x");
    chk({4'h0, cur_y_o}, 16'h0E9C, "R5 cur_y");
    chk(win_x_o, 16'h2211, "R3 win_x");
    chk(win_y_o, 16'h4433, "R3 win_y");
    chk(win_w_o, 16'h6655, "R3 win_w");
    chk(win_h_o, 16'h8877, "R3 win_h");
    rd(2'd0, 16'h000D, "R3 address after stream");
    // R6 writes above 0x0C ignored
    wbyte(2'd2, 8'hFF); wbyte(2'd2, 8'hEE);
    chk({8'h0, cmd_o}, 16'h0061, "R6 cmd kept");
    chk({4'h0, cur_x_o}, 16'h0578, "R6 cur_x kept");
    chk(win_h_o, 16'h8877, "R6 win_h kept");
    rd(2'd0, 16'h000F, "R6 address still advances");
    sel_addr(16'h000D);
    rd(2'd2, 16'h0000, "R6 read 0x0D zero");
    rd(2'd2, 16'h0000, "R6 read 0x0E zero");
    // R4 R9 back-to-back register reads
    sel_addr(16'h0000);
    rd(2'd2, 16'h0061, "R4 cmd");
    rd(2'd2, 16'h0078, "R4 cx lo");
    rd(2'd2, 16'h0005, "R5 cx hi");
    rd(2'd2, 16'h009C, "R4 cy lo");
    rd(2'd2, 16'h000E, "R5 cy hi");
    rd(2'd2, 16'h0011, "R9 wx lo");
    rd(2'd2, 16'h0022, "R9 wx hi");
    rd(2'd2, 16'h0033, "R4 wy lo");
    rd(2'd2, 16'h0044, "R4 wy hi");
    rd(2'd2, 16'h0055, "R4 ww lo");
    rd(2'd2, 16'h0066, "R4 ww hi");
    rd(2'd2, 16'h0077, "R4 wh lo");
    rd(2'd2, 16'h0088, "R4 wh hi");
    // R7 cursor map words at the top edge
    sel_addr(16'h01FE);
    op(2'd3, 1'b1, 16'hC3A5);
    op(2'd3, 1'b1, 16'h5A3C);
    op(2'd3, 1'b1, 16'hFFFF);
    rd(2'd0, 16'h0001, "R7 addr lo after map");
    rd(2'd1, 16'h0002, "R7 addr hi after map");
    rd(2'd3, 16'h0000, "R7 read 0x201 zero");
    sel_addr(16'h01FE);
    rd(2'd3, 16'hC3A5, "R7 map 0x1FE");
    rd(2'd3, 16'h5A3C, "R7 map 0x1FF");
    rd(2'd3, 16'h0000, "R7 map 0x200 zero");
    // R8 wrap
    sel_addr(16'hFFFF);
    rd(2'd2, 16'h0000, "R8 read at 0xFFFF");
    rd(2'd0, 16'h0000, "R8 wrap lo");
    rd(2'd1, 16'h0000, "R8 wrap hi");
    // R10 overlay port and same-word collision
    sel_addr(16'h0010);
    op(2'd3, 1'b1, 16'hAAAA);
    ovl_addr = 9'h010;
    @(negedge clk);
    chk(ovl_rdata, 16'hAAAA, "R10 overlay read");
    ovl_addr = 9'h1FF;
    @(negedge clk);
    chk(ovl_rdata, 16'h5A3C, "R10 overlay 0x1FF");
    ovl_addr = 9'h010;
    sel_addr(16'h0010);
    op(2'd3, 1'b1, 16'hBBBB);
    chk(ovl_rdata, 16'hAAAA, "R10 collision old word");
    @(negedge clk);
    chk(ovl_rdata, 16'hBBBB, "R10 new word next cycle");
    repeat (3) @(negedge clk);
    chk(16'(exp_q.size()), 16'h0, "R9 all reads returned");
    finish_run();
  end
endmodule